// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous, byte-wide parallel NOR flash. It turns a single request into the whole bus conversation the memory expects. A request carries an operation code, a target byte address and a data byte.

For a program or erase, the sequencer first writes the unlock and command bytes to the fixed unlock addresses. It then reads back from the target address until bit 7 of the returned byte matches the expected value. While the embedded operation runs, the memory returns the inverse of that bit. A plain read is a single timed access whose byte is handed back with the completion pulse.

All strobe widths and gaps are counted in system clocks and set by parameters. A polling window that runs past its limit makes the sequencer write a reset command and report an error instead of completion.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, busy, done and error are low, chip select, write enable and output enable are high (inactive), and the data bus is not driven.
- R2: Operation code 1 (program) issues exactly four write cycles: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the request data at the request address.
- R3: Operation code 2 (sector erase) issues six write cycles: AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 30h at the request address.
- R4: Operation code 3 (chip erase) issues the same first five cycles as R3 and ends with 10h written at 5555h.
- R5: In every write cycle, write enable is low for exactly T_WE_LO clocks with chip select low. Address and data stay stable while it is low, and it stays high for at least T_GAP clocks between cycles.
- R6: After the command cycles, the target address is read repeatedly. The operation completes when bit 7 equals bit 7 of the request data (program) or 1 (erase), and done then pulses.
- R7: If the status has not completed once TIMEOUT_CYC clocks of polling have passed, the block writes F0h at address 0, pulses error and never pulses done.
- R8: Operation code 0 (read) performs one read access of T_RD clocks at the request address. The byte is presented on rd_data together with the done pulse.
- R9: A request presented while busy is high is ignored: no extra bus cycles follow, and the running operation is unaffected.
- R10: Write enable and output enable are never low together, and the data bus is never driven while output enable is low.
- R11: done and error are single-cycle pulses and never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle timeout pulse |
| rd_data | output | 8 | Byte returned by a read operation |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Flash data bus, outgoing |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Flash data bus, incoming |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The hardest situation to reach is the timeout abort. The memory has to keep reporting an unfinished operation through many status reads, long enough for the polling window to expire. The bench flash model therefore keeps a per-operation count of busy status reads, returning the inverted bit 7 until that count runs out. Setting the count far beyond the shortened timeout parameter forces the abort path, so the F0h reset write and the error pulse can be checked. Small counts exercise completion after zero, a few and many polls.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

   typedef enum logic [1:0] {
      OP_READ = 2'd0,
      OP_PROG = 2'd1,
      OP_SECT = 2'd2,
      OP_CHIP = 2'd3
   } nor_op_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_STROBE,
      PH_RECOVER
   } bus_phase_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_CMD,
      S_POLL,
      S_ABORT
   } seq_state_e;

   localparam int UNLK_W = 15;
   localparam logic [UNLK_W-1:0] UNLK_HI = 15'h5555;
   localparam logic [UNLK_W-1:0] UNLK_LO = 15'h2AAA;
   localparam logic [7:0] RESET_CMD = 8'hF0;

   typedef struct packed {
      logic              use_tgt;
      logic [UNLK_W-1:0] addr;
      logic [7:0]        data;
   } seq_step_t;

   // One command bus cycle of the unlock/command sequence for a given step.
   function automatic seq_step_t seq_step(nor_op_e op, logic [2:0] idx, logic [7:0] wd);
      seq_step_t s;
      s.use_tgt = 1'b0;
      s.addr    = UNLK_HI;
      s.data    = 8'hAA;
      case (idx)
         3'd0: ;
         3'd1: begin s.addr = UNLK_LO; s.data = 8'h55; end
         3'd2: s.data = (op == OP_PROG) ? 8'hA0 : 8'h80;
         3'd3: if (op == OP_PROG) begin s.use_tgt = 1'b1; s.data = wd; end
         3'd4: begin s.addr = UNLK_LO; s.data = 8'h55; end
         default: begin
            if (op == OP_SECT) begin s.use_tgt = 1'b1; s.data = 8'h30; end
            else s.data = 8'h10;
         end
      endcase
      return s;
   endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
   import nor_seq_pkg::*;
#(
   parameter int AW      = 19,
   parameter int T_WE_LO = 4,
   parameter int T_GAP   = 2,
   parameter int T_RD    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rd,
   input  logic [AW-1:0] addr_in,
   input  logic [7:0]    wdata,
   input  logic [7:0]    dq_in,
   output logic          cyc_done,
   output logic [7:0]    rdata,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_dq_out,
   output logic          fl_dq_oe,
   output logic          fl_cs_n,
   output logic          fl_we_n,
   output logic          fl_oe_n
);
   localparam int MAXL = (T_WE_LO > T_RD) ? ((T_WE_LO > T_GAP) ? T_WE_LO : T_GAP)
                                          : ((T_RD > T_GAP) ? T_RD : T_GAP);
   localparam int CW = $clog2(MAXL + 1);
   localparam logic [CW-1:0] WR_LAST  = CW'(T_WE_LO - 1);
   localparam logic [CW-1:0] RD_LAST  = CW'(T_RD - 1);
   localparam logic [CW-1:0] GAP_LAST = CW'(T_GAP - 1);

   if (T_WE_LO < 1) begin : g_bad_wlo
      $error("T_WE_LO must be at least 1");
   end
   if (T_GAP < 1) begin : g_bad_gap
      $error("T_GAP must be at least 1");
   end
   if (T_RD < 1) begin : g_bad_rd
      $error("T_RD must be at least 1");
   end

   bus_phase_e    ph;
   logic [CW-1:0] cnt;
   logic          rd_q;
   logic [CW-1:0] stb_last;

   assign stb_last = rd_q ? RD_LAST : WR_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         cnt       <= '0;
         rd_q      <= 1'b0;
         fl_addr   <= '0;
         fl_dq_out <= '0;
         rdata     <= '0;
         cyc_done  <= 1'b0;
      end else begin
         cyc_done <= 1'b0;
         case (ph)
            PH_IDLE: if (start) begin
               ph        <= PH_STROBE;
               cnt       <= '0;
               rd_q      <= rd;
               fl_addr   <= addr_in;
               fl_dq_out <= wdata;
            end
            PH_STROBE: begin
               if (cnt == stb_last) begin
                  ph  <= PH_RECOVER;
                  cnt <= '0;
                  if (rd_q) rdata <= dq_in;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (cnt == GAP_LAST) begin
                  ph       <= PH_IDLE;
                  cyc_done <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign fl_cs_n  = !((ph == PH_STROBE) || ((ph == PH_RECOVER) && !rd_q));
   assign fl_we_n  = !((ph == PH_STROBE) && !rd_q);
   assign fl_oe_n  = !((ph == PH_STROBE) && rd_q);
   assign fl_dq_oe = (ph != PH_IDLE) && !rd_q;

   // Checker-side counter of consecutive write-enable low clocks.
   logic [CW:0] we_lo_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_lo_run <= '0;
      else if (!fl_we_n) we_lo_run <= we_lo_run + 1'b1;
      else we_lo_run <= '0;
   end

   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n) |-> (we_lo_run == (CW+1)'(T_WE_LO))); // R5
   AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out))); // R5
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_oe_n)); // R10
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> !fl_dq_oe); // R10

endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
   parameter int unsigned LIMIT = 32'd1_600_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int TW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("LIMIT must be at least 1");
   end

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (!run) cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == TW'(LIMIT));

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (run && expired) |=> (expired || !$past(run))); // R7

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_seq_pkg::*;
#(
   parameter int          AW          = 19,
   parameter int          T_WE_LO     = 4,
   parameter int          T_GAP       = 2,
   parameter int          T_RD        = 7,
   parameter int unsigned TIMEOUT_CYC = 32'd1_600_000_000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   output logic          busy,
   output logic          done,
   output logic          error,
   output logic [7:0]    rd_data,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_dq_out,
   output logic          fl_dq_oe,
   input  logic [7:0]    fl_dq_in,
   output logic          fl_cs_n,
   output logic          fl_we_n,
   output logic          fl_oe_n
);
   if (AW < UNLK_W) begin : g_bad_aw
      $error("AW must cover the unlock addresses");
   end

   seq_state_e    st;
   nor_op_e       op_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    data_q;
   logic [2:0]    step_q;
   logic          pending;

   seq_step_t     cur;
   logic [2:0]    last_step;
   logic          start;
   logic          bus_rd;
   logic [AW-1:0] bus_addr;
   logic [7:0]    bus_wdata;
   logic          cyc_done;
   logic [7:0]    bus_rdata;
   logic          tmo_run;
   logic          tmo_hit;
   logic          exp_bit7;

   assign cur       = seq_step(op_q, step_q, data_q);
   assign last_step = (op_q == OP_PROG) ? 3'd3 : 3'd5;
   assign exp_bit7  = (op_q == OP_PROG) ? data_q[7] : 1'b1;
   assign start     = (st != S_IDLE) && !pending;
   assign bus_rd    = (st == S_POLL);
   assign tmo_run   = (st == S_POLL) && (op_q != OP_READ);

   always_comb begin
      bus_addr  = addr_q;
      bus_wdata = cur.data;
      if (st == S_CMD && !cur.use_tgt) bus_addr = AW'(cur.addr);
      if (st == S_ABORT) begin
         bus_addr  = '0;
         bus_wdata = RESET_CMD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         op_q    <= OP_READ;
         addr_q  <= '0;
         data_q  <= '0;
         step_q  <= '0;
         pending <= 1'b0;
         done    <= 1'b0;
         error   <= 1'b0;
         rd_data <= '0;
      end else begin
         done  <= 1'b0;
         error <= 1'b0;
         if (start) pending <= 1'b1;
         else if (cyc_done) pending <= 1'b0;
         case (st)
            S_IDLE: if (req_valid) begin
               op_q   <= nor_op_e'(req_op);
               addr_q <= req_addr;
               data_q <= req_data;
               step_q <= '0;
               st     <= (nor_op_e'(req_op) == OP_READ) ? S_POLL : S_CMD;
            end
            S_CMD: if (cyc_done) begin
               if (step_q == last_step) st <= S_POLL;
               else step_q <= step_q + 1'b1;
            end
            S_POLL: if (cyc_done) begin
               if (op_q == OP_READ) begin
                  rd_data <= bus_rdata;
                  done    <= 1'b1;
                  st      <= S_IDLE;
               end else if (bus_rdata[7] == exp_bit7) begin
                  done <= 1'b1;
                  st   <= S_IDLE;
               end else if (tmo_hit) begin
                  st <= S_ABORT;
               end
            end
            default: if (cyc_done) begin
               error <= 1'b1;
               st    <= S_IDLE;
            end
         endcase
      end
   end

   assign busy = (st != S_IDLE);

   nor_bus_cycle #(
      .AW(AW), .T_WE_LO(T_WE_LO), .T_GAP(T_GAP), .T_RD(T_RD)
   ) i_bus (
      .clk(clk), .rst_n(rst_n), .start(start), .rd(bus_rd),
      .addr_in(bus_addr), .wdata(bus_wdata), .dq_in(fl_dq_in),
      .cyc_done(cyc_done), .rdata(bus_rdata),
      .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
      .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
   );

   nor_poll_timer #(.LIMIT(TIMEOUT_CYC)) i_tmo (
      .clk(clk), .rst_n(rst_n), .run(tmo_run), .expired(tmo_hit)
   );

   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error)); // R11
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> !error); // R11
   AST_ABORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (fl_dq_out == RESET_CMD && fl_addr == '0)); // R7
   AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> fl_cs_n); // R9

endmodule

// File: tb/test_nor_cmd_seq.sv
module test_nor_cmd_seq;
   localparam int AW   = 19;
   localparam int TWLO = 4;
   localparam int TGAP = 2;
   localparam int TRD  = 5;
   localparam int TMO  = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          req_valid = 1'b0;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = '0;
   logic          busy, done, error;
   logic [7:0]    rd_data;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_dq_out;
   logic          fl_dq_oe;
   logic [7:0]    fl_dq_in;
   logic          fl_cs_n, fl_we_n, fl_oe_n;

   nor_cmd_seq #(.AW(AW), .T_WE_LO(TWLO), .T_GAP(TGAP), .T_RD(TRD),
                 .TIMEOUT_CYC(TMO)) i_nor_cmd_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
      .error(error), .rd_data(rd_data), .fl_addr(fl_addr),
      .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
      .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
   );

   // Flash model: busy polls return inverted bit 7, then the final byte.
   int         polls_left = 0;
   logic       exp7 = 1'b0;
   logic [7:0] final_val = '0;
   logic [7:0] model_val;
   assign model_val = (polls_left > 0) ? {~exp7, 7'h2A} : final_val;
   assign fl_dq_in  = (!fl_cs_n && !fl_oe_n) ? model_val : 8'h00;
   always @(posedge fl_oe_n) if (polls_left > 0) polls_left <= polls_left - 1;

   int            wcnt = 0;
   logic [AW-1:0] wlog_a [16];
   logic [7:0]    wlog_d [16];
   always @(posedge fl_we_n) if (rst_n && wcnt < 16) begin
      wlog_a[wcnt] = fl_addr;
      wlog_d[wcnt] = fl_dq_out;
      wcnt = wcnt + 1;
   end

   // Bus monitors sampled away from the active edge.
   int lo_run = 0, width_bad = 0, high_run = 100, gap_bad = 0, dir_bad = 0, idle_sel = 0;
   always @(negedge clk) if (rst_n) begin
      if (!fl_we_n) begin
         if (lo_run == 0 && high_run < TGAP) gap_bad++;
         lo_run++;
         if (fl_cs_n) width_bad++;
      end else begin
         if (lo_run != 0 && lo_run != TWLO) width_bad++;
         if (lo_run != 0) high_run = 0;
         lo_run = 0;
         high_run++;
      end
      if (!fl_oe_n && fl_dq_oe) dir_bad++;
      if (!fl_oe_n && !fl_we_n) dir_bad++;
      if (!busy && !fl_cs_n) idle_sel++;
   end

   int n_chk = 0, n_fail = 0;
   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected write cycle i of an operation, from the requirement text.
   function automatic void exp_write(input logic [1:0] op, input logic [AW-1:0] a,
                                     input logic [7:0] d, input int i,
                                     output logic [AW-1:0] ea, output logic [7:0] ed);
      logic [AW-1:0] ua [5];
      logic [7:0]    ud [5];
      ua = '{19'h5555, 19'h2AAA, 19'h5555, 19'h5555, 19'h2AAA};
      ud = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55};
      if (op == 2'd1) begin
         if (i == 3) begin ea = a; ed = d; end
         else begin ea = ua[i]; ed = (i == 2) ? 8'hA0 : ud[i]; end
      end else if (i < 5) begin
         ea = ua[i]; ed = ud[i];
      end else if (op == 2'd2) begin
         ea = a; ed = 8'h30;
      end else begin
         ea = 19'h5555; ed = 8'h10;
      end
   endfunction

   typedef struct packed {
      logic [1:0]    op;
      logic [AW-1:0] addr;
      logic [7:0]    data;
      logic [15:0]   npoll;
      logic          err;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 19'h12345, 8'h5A, 16'd0,    1'b0},
      '{2'd1, 19'h00010, 8'h3C, 16'd3,    1'b0},
      '{2'd1, 19'h7FFFF, 8'hC5, 16'd0,    1'b0},
      '{2'd2, 19'h30000, 8'h00, 16'd10,   1'b0},
      '{2'd3, 19'h01234, 8'h00, 16'd2,    1'b0},
      '{2'd1, 19'h4AAAA, 8'h81, 16'd9999, 1'b1},
      '{2'd0, 19'h7FFFF, 8'hA7, 16'd0,    1'b0},
      '{2'd2, 19'h10000, 8'h00, 16'd9999, 1'b1}
   };

   task automatic run_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                          output bit got_done, output bit got_err);
      int cyc;
      @(negedge clk);
      req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (!(done || error) && cyc < 3000) begin
         @(negedge clk);
         cyc++;
      end
      got_done = done;
      got_err  = error;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      bit gd, ge;
      int nexp;
      logic [AW-1:0] ea;
      logic [7:0] ed;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !error, "R1 status", {busy, done, error}, 0);
      chk(fl_cs_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R1 strobes",
          {fl_cs_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && fl_cs_n, "R1 after release", {busy, fl_cs_n}, 2'b01);

      for (int v = 0; v < NV; v++) begin
         vec_t t;
         t = VECS[v];
         polls_left = int'(t.npoll);
         exp7       = (t.op == 2'd1) ? t.data[7] : 1'b1;
         final_val  = (t.op == 2'd2 || t.op == 2'd3) ? 8'hFF : t.data;
         wcnt = 0; width_bad = 0; gap_bad = 0;
         run_req(t.op, t.addr, t.data, gd, ge);
         // R6 completion / R7 timeout outcome
         chk(gd == !t.err && ge == t.err, t.err ? "R7 error outcome" : "R6 done outcome",
             {gd, ge}, {!t.err, t.err});
         @(negedge clk);
         chk(!done && !error, "R11 single pulse", {done, error}, 0);
         nexp = (t.op == 2'd0) ? 0 : (t.op == 2'd1) ? 4 : 6;
         if (t.err) nexp++;
         chk(wcnt == nexp, "R2 R3 R4 write count", wcnt, nexp);
         for (int i = 0; i < nexp && i < wcnt; i++) begin
            if (t.err && i == nexp - 1) begin ea = '0; ed = 8'hF0; end
            else exp_write(t.op, t.addr, t.data, i, ea, ed);
            chk(wlog_a[i] == ea && wlog_d[i] == ed,
                t.err && i == nexp - 1 ? "R7 reset write" :
                t.op == 2'd1 ? "R2 program cycle" :
                t.op == 2'd2 ? "R3 sector cycle" : "R4 chip cycle",
                {wlog_a[i], wlog_d[i]}, {ea, ed});
         end
         if (t.op == 2'd0) chk(rd_data == t.data, "R8 read data", rd_data, t.data);
         chk(width_bad == 0 && gap_bad == 0, "R5 strobe timing", {width_bad, gap_bad}, 0);
      end

      // R9: request during an operation is ignored.
      polls_left = 4; exp7 = 1'b0; final_val = 8'h11; wcnt = 0; idle_sel = 0;
      @(negedge clk);
      req_op = 2'd1; req_addr = 19'h00100; req_data = 8'h11; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      req_op = 2'd3; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      begin
         int cyc = 0;
         while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
      end
      chk(wcnt == 4 && wlog_a[3] == 19'h00100 && wlog_d[3] == 8'h11,
          "R9 running op intact", {wcnt[7:0], wlog_d[3]}, {8'd4, 8'h11});
      repeat (30) @(negedge clk);
      chk(!busy && wcnt == 4, "R9 no extra cycles", {busy, wcnt[7:0]}, {1'b0, 8'd4});
      chk(idle_sel == 0, "R9 idle deselect", idle_sel, 0);
      chk(dir_bad == 0, "R10 strobe exclusion", dir_bad, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule